// File: doc/BRIEF.md
# Configuration Port Word Sequencer

This block produces the complete word stream that a device configuration port needs in order to write or read back a rectangular group of configuration frames. Software or a control state machine only supplies a list of frame addresses (through a show-ahead address FIFO) and, for writes, the raw frame contents. The sequencer adds everything else itself. It opens with a fixed command header. For each frame it then sends a short per-frame command group that carries the frame address, followed by the frame payload. It closes with a fixed tail. None of the command words need to be stored in memory or found by parsing a bitstream.

A one-cycle `start` launches an operation, and `rd_mode` selects write tables or readback tables at that moment. The address FIFO ends the frame loop by presenting an all-ones word. In readback mode the payload slots are emitted as read requests, which the port serves. The write data input is then left untouched. The output uses a valid/ready handshake, and any stall on the output, the address FIFO or the data input holds the sequence in place. A one-cycle `done` pulse marks the end of the operation.

Top module: `cfg_word_sequencer`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done`, `out_valid`, `addr_ready` and `din_ready` are all low.
- R2: `start` is taken only while idle, and `rd_mode` is captured at that moment (0 = write, 1 = readback). A `start` pulse or a change of `rd_mode` during an operation has no effect on the stream.
- R3: The stream opens with the header. Header word i equals {4'hE, kind[3:0], i[7:0], 16'h3C5A + 16'h0101*i}. For a write, kind is 0 and there are 14 words. For a readback, kind is 1 and there are 6 words.
- R4: Each frame opens with 5 words in this order: word 0 is the address-command word (the word formula with kind 4, i = 0); word 1 is the address taken from the FIFO; words 2..4 use the formula with i = 2..4 and kind 5 for a write or kind 6 for a readback.
- R5: In write mode each frame then carries 41 payload words. They are taken from `din_data` in arrival order, and a word is consumed only in a cycle where `din_valid`, `din_ready` and `out_ready` are all high.
- R6: In readback mode the 41 payload slots appear with `out_read` = 1 and `out_data` = 0. `din_ready` stays low for the whole operation, so no write data is consumed.
- R7: An all-ones address at the FIFO head is popped without emitting any word and ends the frame loop. An operation whose first address is the marker emits only the header and the tail. Exactly (frames + 1) addresses are popped per operation.
- R8: The write tail is one pad frame of 41 zero words (`out_read` = 0) followed by 9 words with kind 2. The readback tail is 2 words with kind 3 and has no pad frame.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_read` hold. Stalls on any side neither drop nor repeat a word.
- R10: `done` pulses for exactly one cycle, in the cycle after the last tail word is accepted, and `busy` is low from then on. With no stalls, `done` rises H + 46*F + 1 + P + T clock edges after the edge that takes `start`, where H is the header length, F the frame count, P is 41 for writes and 0 for readback, and T the tail length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches an operation when idle |
| rd_mode | input | 1 | 0 = write tables, 1 = readback tables; sampled with start |
| addr_valid | input | 1 | Address FIFO has a word at its head |
| addr_data | input | DATA_W | Frame address at the FIFO head; all ones ends the loop |
| addr_ready | output | 1 | Pops the address FIFO |
| din_valid | input | 1 | Write payload word available |
| din_data | input | DATA_W | Write payload word |
| din_ready | output | 1 | Payload word consumed |
| out_valid | output | 1 | Stream word valid |
| out_data | output | DATA_W | Stream word |
| out_read | output | 1 | Word is a readback request slot rather than data to write |
| out_ready | input | 1 | Port accepts the stream word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the last tail word |

## Verification
The hardest situation to reach is a stall landing on one of the two slots that read the address FIFO. One case is the address slot inside a frame prefix. The other is the marker pop, which produces no output word and must not repeat or lose an address. The bench reaches both by running every mode against frame counts from zero to three under three stall patterns. A free-running shift register independently deasserts the port's ready and withholds FIFO and data words. The sources keep a presented word valid until it is taken, so stalls fall on every phase boundary, including the marker cycle.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HEAD,
    PH_PREFIX,
    PH_PAYLOAD,
    PH_PAD,
    PH_TAIL
  } phase_e;

  localparam logic [3:0] K_HEAD_WR = 4'd0;
  localparam logic [3:0] K_HEAD_RD = 4'd1;
  localparam logic [3:0] K_TAIL_WR = 4'd2;
  localparam logic [3:0] K_TAIL_RD = 4'd3;
  localparam logic [3:0] K_ADDR_CMD = 4'd4;
  localparam logic [3:0] K_PFX_WR = 4'd5;
  localparam logic [3:0] K_PFX_RD = 4'd6;

  // Constant command word for table kind and slot index
  function automatic logic [31:0] seq_word(logic [3:0] kind, logic [7:0] slot);
    logic [15:0] low;
    low = 16'h3C5A + ({8'h00, slot} * 16'h0101);
    return {4'hE, kind, slot, low};
  endfunction

endpackage

// File: rtl/cfgseq_phase_ctl.sv
module cfgseq_phase_ctl
  import cfgseq_pkg::*;
#(
  parameter int HEAD_WR_LEN = 14,
  parameter int HEAD_RD_LEN = 6,
  parameter int TAIL_WR_LEN = 9,
  parameter int TAIL_RD_LEN = 2,
  parameter int PREFIX_LEN  = 5,
  parameter int FRAME_WORDS = 41,
  parameter int CW          = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_mode_in,
  input  logic          word_fire,
  input  logic          marker_pop,
  output phase_e        phase,
  output logic [CW-1:0] idx,
  output logic          mode_q,
  output logic          done,
  output logic          seq_last
);

  function automatic int slot_count(phase_e ph, logic rd);
    case (ph)
      PH_HEAD:    return rd ? HEAD_RD_LEN : HEAD_WR_LEN;
      PH_PREFIX:  return PREFIX_LEN;
      PH_PAYLOAD: return FRAME_WORDS;
      PH_PAD:     return FRAME_WORDS;
      PH_TAIL:    return rd ? TAIL_RD_LEN : TAIL_WR_LEN;
      default:    return 1;
    endcase
  endfunction

  function automatic phase_e phase_after(phase_e ph);
    case (ph)
      PH_HEAD:    return PH_PREFIX;
      PH_PREFIX:  return PH_PAYLOAD;
      PH_PAYLOAD: return PH_PREFIX;
      PH_PAD:     return PH_TAIL;
      default:    return PH_IDLE;
    endcase
  endfunction

  always_comb seq_last = (idx == CW'(slot_count(phase, mode_q) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      mode_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase  <= PH_HEAD;
          idx    <= '0;
          mode_q <= rd_mode_in;
        end
      end else if (marker_pop) begin
        phase <= mode_q ? PH_TAIL : PH_PAD;
        idx   <= '0;
      end else if (word_fire) begin
        if (seq_last) begin
          idx   <= '0;
          phase <= phase_after(phase);
          if (phase == PH_TAIL) done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cfgseq_word_mux.sv
module cfgseq_word_mux
  import cfgseq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CW     = 6
) (
  input  phase_e            phase,
  input  logic [CW-1:0]     idx,
  input  logic              mode_q,
  input  logic              addr_valid,
  input  logic [DATA_W-1:0] addr_data,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_read,
  output logic              addr_ready,
  output logic              din_ready,
  output logic              marker_pop,
  output logic              word_fire
);

  logic       is_marker;
  logic [7:0] slot;

  assign is_marker = &addr_data;
  assign slot      = 8'(idx);

  always_comb begin
    out_valid  = 1'b0;
    out_data   = '0;
    out_read   = 1'b0;
    addr_ready = 1'b0;
    din_ready  = 1'b0;
    marker_pop = 1'b0;
    case (phase)
      PH_HEAD: begin
        out_valid = 1'b1;
        out_data  = DATA_W'(seq_word(mode_q ? K_HEAD_RD : K_HEAD_WR, slot));
      end
      PH_PREFIX: begin
        if (idx == '0) begin
          if (addr_valid && is_marker) begin
            addr_ready = 1'b1;
            marker_pop = 1'b1;
          end else begin
            out_valid = addr_valid;
            out_data  = DATA_W'(seq_word(K_ADDR_CMD, 8'h00));
          end
        end else if (idx == CW'(1)) begin
          out_valid  = addr_valid;
          out_data   = addr_data;
          addr_ready = out_ready;
        end else begin
          out_valid = 1'b1;
          out_data  = DATA_W'(seq_word(mode_q ? K_PFX_RD : K_PFX_WR, slot));
        end
      end
      PH_PAYLOAD: begin
        if (mode_q) begin
          out_valid = 1'b1;
          out_read  = 1'b1;
        end else begin
          out_valid = din_valid;
          out_data  = din_data;
          din_ready = out_ready;
        end
      end
      PH_PAD: begin
        out_valid = 1'b1;
      end
      PH_TAIL: begin
        out_valid = 1'b1;
        out_data  = DATA_W'(seq_word(mode_q ? K_TAIL_RD : K_TAIL_WR, slot));
      end
      default: ;
    endcase
  end

  assign word_fire = out_valid && out_ready;

endmodule

// File: rtl/cfg_word_sequencer.sv
module cfg_word_sequencer
  import cfgseq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FRAME_WORDS = 41,
  parameter int HEAD_WR_LEN = 14,
  parameter int HEAD_RD_LEN = 6,
  parameter int TAIL_WR_LEN = 9,
  parameter int TAIL_RD_LEN = 2,
  parameter int PREFIX_LEN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_mode,
  input  logic              addr_valid,
  input  logic [DATA_W-1:0] addr_data,
  output logic              addr_ready,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  output logic              din_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_read,
  input  logic              out_ready,
  output logic              busy,
  output logic              done
);

  localparam int MAX_A   = (HEAD_WR_LEN > HEAD_RD_LEN) ? HEAD_WR_LEN : HEAD_RD_LEN;
  localparam int MAX_B   = (TAIL_WR_LEN > TAIL_RD_LEN) ? TAIL_WR_LEN : TAIL_RD_LEN;
  localparam int MAX_C   = (FRAME_WORDS > PREFIX_LEN) ? FRAME_WORDS : PREFIX_LEN;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_LEN = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CW      = $clog2(MAX_LEN + 1);

  phase_e        phase;
  logic [CW-1:0] idx;
  logic          mode_q;
  logic          word_fire;
  logic          marker_pop;
  logic          seq_last;

  cfgseq_phase_ctl #(
    .HEAD_WR_LEN(HEAD_WR_LEN), .HEAD_RD_LEN(HEAD_RD_LEN),
    .TAIL_WR_LEN(TAIL_WR_LEN), .TAIL_RD_LEN(TAIL_RD_LEN),
    .PREFIX_LEN(PREFIX_LEN), .FRAME_WORDS(FRAME_WORDS), .CW(CW)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode_in(rd_mode),
    .word_fire(word_fire), .marker_pop(marker_pop),
    .phase(phase), .idx(idx), .mode_q(mode_q), .done(done), .seq_last(seq_last)
  );

  cfgseq_word_mux #(.DATA_W(DATA_W), .CW(CW)) u_mux (
    .phase(phase), .idx(idx), .mode_q(mode_q),
    .addr_valid(addr_valid), .addr_data(addr_data),
    .din_valid(din_valid), .din_data(din_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_read(out_read),
    .addr_ready(addr_ready), .din_ready(din_ready),
    .marker_pop(marker_pop), .word_fire(word_fire)
  );

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker
  import cfgseq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_read,
  input logic              addr_ready,
  input logic              din_ready,
  input logic              busy,
  input logic              done,
  input logic              mode_q,
  input logic              marker_pop,
  input logic              word_fire,
  input logic              seq_last,
  input phase_e            phase
);

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (!busy && !done && !out_valid && !addr_ready && !din_ready);
    end
  end

  a_r2_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (mode_q == $past(mode_q)));

  a_r6_no_din_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q) |-> !din_ready);

  a_r6_read_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_read |-> (out_data == '0));

  a_r7_marker_silent: assert property (@(posedge clk) disable iff (!rst_n)
    marker_pop |-> (!out_valid && !word_fire));

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_read)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_done_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(word_fire && seq_last && (phase == PH_TAIL)));

endmodule

bind cfg_word_sequencer cfgseq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_read(out_read),
  .addr_ready(addr_ready), .din_ready(din_ready), .busy(busy), .done(done),
  .mode_q(mode_q), .marker_pop(marker_pop), .word_fire(word_fire),
  .seq_last(seq_last), .phase(phase)
);

// File: tb/cfg_word_sequencer_bench.sv
module cfg_word_sequencer_bench;

  localparam int DW = 32;
  localparam int FW = 41;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          rd_mode = 1'b0;
  logic          addr_valid = 1'b0;
  logic [DW-1:0] addr_data = '0;
  logic          addr_ready;
  logic          din_valid = 1'b0;
  logic [DW-1:0] din_data = '0;
  logic          din_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_read;
  logic          out_ready = 1'b0;
  logic          busy;
  logic          done;

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] exp_data [0:511];
  logic          exp_rd   [0:511];
  int            exp_req  [0:511];
  logic [DW-1:0] act_data [0:511];
  logic          act_rd   [0:511];
  logic [15:0]   lfsr = 16'hACE1;

  always #2 clk = ~clk;

  cfg_word_sequencer u_cfg_word_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
    .addr_valid(addr_valid), .addr_data(addr_data), .addr_ready(addr_ready),
    .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
    .out_valid(out_valid), .out_data(out_data), .out_read(out_read),
    .out_ready(out_ready), .busy(busy), .done(done)
  );

  function automatic string req_tag(int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] cmd_word(int kind, int i);
    logic [7:0] b;
    b = 8'(i);
    return {4'hE, 4'(kind), b, 16'h3C5A + {b, b}};
  endfunction

  task automatic check(input bit ok, input int r, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req_tag(r), what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic run_case(input bit md, input int nfr, input int pat, input int run_id);
    int ne;
    int na;
    int a_ptr;
    int d_ptr;
    int dones;
    int done_win;
    int last_fire;
    int hlen;
    int tlen;
    int total;
    bit a_hold;
    bit d_hold;
    bit go;
    bit rdy;
    ne = 0;
    hlen = md ? 6 : 14;
    tlen = md ? 2 : 9;
    for (int i = 0; i < hlen; i++) begin
      exp_data[ne] = cmd_word(md ? 1 : 0, i); exp_rd[ne] = 0; exp_req[ne] = 3; ne++;
    end
    for (int f = 0; f < nfr; f++) begin
      exp_data[ne] = cmd_word(4, 0); exp_rd[ne] = 0; exp_req[ne] = 4; ne++;
      exp_data[ne] = 32'h0040_0000 + run_id * 256 + f * 3; exp_rd[ne] = 0; exp_req[ne] = 4; ne++;
      for (int i = 2; i < 5; i++) begin
        exp_data[ne] = cmd_word(md ? 6 : 5, i); exp_rd[ne] = 0; exp_req[ne] = 4; ne++;
      end
      for (int w = 0; w < FW; w++) begin
        exp_data[ne] = md ? 32'h0 : (32'hD000_0000 + run_id * 65536 + f * FW + w);
        exp_rd[ne] = md; exp_req[ne] = md ? 6 : 5; ne++;
      end
    end
    if (!md) begin
      for (int w = 0; w < FW; w++) begin
        exp_data[ne] = 32'h0; exp_rd[ne] = 0; exp_req[ne] = 8; ne++;
      end
    end
    for (int i = 0; i < tlen; i++) begin
      exp_data[ne] = cmd_word(md ? 3 : 2, i); exp_rd[ne] = 0; exp_req[ne] = 8; ne++;
    end

    na = 0; a_ptr = 0; d_ptr = 0; dones = 0; done_win = -1; last_fire = -1;
    a_hold = 0; d_hold = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      start   = (cyc == 0) || (cyc == 5);
      rd_mode = (cyc == 0) ? md : ~md;
      case (pat)
        0: begin rdy = 1; go = 1; end
        1: begin rdy = lfsr[0] | lfsr[1]; go = !(lfsr[2] & lfsr[3]); end
        default: begin rdy = lfsr[4]; go = lfsr[5]; end
      endcase
      out_ready  = rdy;
      addr_valid = a_hold || (go && a_ptr <= nfr);
      addr_data  = (a_ptr < nfr) ? (32'h0040_0000 + run_id * 256 + a_ptr * 3) : '1;
      din_valid  = d_hold || go;
      din_data   = 32'hD000_0000 + run_id * 65536 + d_ptr;
      #1;
      if (cyc == 0) check(!busy, 2, "idle before start edge", {31'b0, busy}, 0);
      if (out_valid && out_ready) begin
        if (na < 512) begin act_data[na] = out_data; act_rd[na] = out_read; end
        na++;
        last_fire = cyc;
      end
      a_hold = addr_valid && !addr_ready;
      d_hold = din_valid && !din_ready;
      if (addr_valid && addr_ready) a_ptr++;
      if (din_valid && din_ready) d_ptr++;
      if (done) begin
        dones++;
        if (done_win < 0) done_win = cyc;
        check(!busy, 10, "busy low with done", {31'b0, busy}, 0);
      end
      if (done_win >= 0 && cyc >= done_win + 3) break;
    end

    check(na == ne, 3, $sformatf("word count md=%0d n=%0d p=%0d", md, nfr, pat), na, ne);
    for (int k = 0; k < ne && k < na; k++) begin
      check(act_data[k] === exp_data[k] && act_rd[k] === exp_rd[k], exp_req[k],
            $sformatf("word %0d md=%0d n=%0d p=%0d rd=%0b", k, md, nfr, pat, act_rd[k]),
            act_data[k], exp_data[k]);
    end
    check(a_ptr == nfr + 1, 7, "addresses popped", a_ptr, nfr + 1);
    check(d_ptr == (md ? 0 : nfr * FW), md ? 6 : 5, "payload words consumed",
          d_ptr, md ? 0 : nfr * FW);
    check(dones == 1, 10, "done pulse count", dones, 1);
    check(done_win == last_fire + 1, 10, "done after last word", done_win, last_fire + 1);
    if (pat == 0) begin
      total = hlen + nfr * (5 + FW) + 1 + (md ? 0 : FW) + tlen;
      check(done_win == total + 1, 10, "unstalled latency", done_win, total + 1);
    end
    if (pat != 0) check(na == ne, 9, "no loss or repeat under stalls", na, ne);
    start = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int run_id;
    run_id = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !out_valid && !addr_ready && !din_ready, 1, "reset state",
          {27'b0, busy, done, out_valid, addr_ready, din_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!busy && !out_valid && !done, 1, "after reset release",
          {29'b0, busy, out_valid, done}, 0);
    for (int pat = 0; pat < 3; pat++) begin
      for (int md = 0; md < 2; md++) begin
        for (int n = 0; n < 4; n++) begin
          run_case(md[0], n, pat, run_id);
          run_id++;
        end
      end
    end
    finish_run();
  end

endmodule